// File: doc/BRIEF.md
# Priority Interrupt Acceptance Unit

This block is the processor-side front end for device interrupts. At each instruction boundary it looks at a 3-bit request level and a vector number offered by the devices. It compares the level with the 3-bit priority mask held in its own status register and decides whether to enter a handler. When it accepts, it saves the return state on the supervisor stack through a request/acknowledge memory port. It then raises the handler priority and enters supervisor mode. Next it reads the handler address from a vector table of 32-bit entries at vector×4, and issues a jump pulse with that address.

The same stack machinery runs backwards for return-from-exception. A start pulse makes the unit pop the saved status word and then the saved program counter, which restores the earlier mode and mask, and jump to the restored address. Software may rewrite the status register between operations, but the mode and mask bits are protected while the unit is in user mode. The highest level cannot be masked and is taken once for each rising transition onto it.

Top module: `prio_irq_unit`

## Requirements
- R1: After reset the status register reads 0x2700 (supervisor bit 13 set, mask bits 10:8 all ones), the stack pointer equals STACK_TOP, and busy, accept, jump and mem_req are low.
- R2: A request at level 1 to 6 is accepted only when it is strictly greater than the current mask and is present in a cycle with the boundary strobe high while the unit is idle. Level 0 is never accepted.
- R3: Level 7 is accepted whatever the mask, once per rising transition of the request onto level 7. A request held at 7 is not taken again. A transition seen while the unit cannot accept stays pending until the next boundary.
- R4: On acceptance the unit first writes the 32-bit boundary PC as a long at SP-4. It then writes the pre-entry 16-bit status register as a word at SP-6, leaving SP lowered by 6. Multi-byte values are big-endian.
- R5: After the status push, bit 13 is set and the mask field becomes the accepted level. A one-cycle accept pulse shows the level and vec_addr = vector×4. A long read at vec_addr follows, and its data leaves on jump_pc with a one-cycle jump pulse.
- R6: A return start reads a word at SP into the status register, then a long at SP+2 as the return address. SP ends raised by 6 and a jump pulse carries the restored address.
- R7: An idle status-register write replaces all 16 bits in supervisor mode (bit 13 = 1). In user mode it changes only bits 7:0, so the mask and mode are unchanged.
- R8: mem_req stays high with a stable address until mem_ack; each access completes in the cycle mem_ack is seen.
- R9: A return start in the same cycle as an acceptable request wins; the request is not taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary | input | 1 | Instruction-boundary strobe; requests are sampled only here |
| req_level | input | 3 | Encoded request level, 0 = none |
| req_vector | input | 8 | Vector number supplied with the request |
| cur_pc | input | 32 | PC to be saved on acceptance |
| rte_start | input | 1 | Start a return-from-exception |
| sr_wr_en | input | 1 | Software status-register write strobe |
| sr_wr_data | input | 16 | Software status-register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_long | output | 1 | 1 = 32-bit access, 0 = 16-bit access |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data (word accesses use bits 15:0) |
| mem_ack | input | 1 | Access completion |
| mem_rdata | input | 32 | Read data (word accesses use bits 15:0) |
| busy | output | 1 | A stacking or restore sequence is in progress |
| accept | output | 1 | One-cycle pulse when a request is taken |
| accept_level | output | 3 | Level of the taken request |
| vec_addr | output | 32 | Vector-table address of the taken request |
| jump | output | 1 | One-cycle pulse with a new program counter |
| jump_pc | output | 32 | Handler or return address |
| sr | output | 16 | Current status register |
| sp | output | 32 | Current supervisor stack pointer |

## Verification
Directed cases drive levels one below, equal to and above the mask, and a level above the mask with the strobe low. Together these show whether the compare is strict and whether sampling is gated by the strobe. Level 7 is driven under a full mask, held across a second strobe, and dropped and raised again. This shows whether acceptance follows the transition rather than the level. A return issued in the same cycle as a fresh level-7 edge checks that the return wins and that the edge stays pending. A user-mode write of the mask bits checks the mode protection. A seeded random mix of levels, vectors, PCs, strobes, returns and status writes, with random acknowledge delays, is compared with a bench model of the mask, pending edge, stack pointer and frame stack.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the priority interrupt acceptance unit.
// Assumes a 16-bit status register with the mode bit and mask field
// at the positions below; both are decoded by neighbouring logic.
package irq_pkg;

    // Sequencer states: idle, entry stacking, vector read, return restore
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_PC = 3'd1,
        ST_PUSH_SR = 3'd2,
        ST_VEC_RD  = 3'd3,
        ST_POP_SR  = 3'd4,
        ST_POP_PC  = 3'd5
    } seq_state_t;

    localparam int SR_SUPER_BIT = 13;   // supervisor/user mode
    localparam int SR_MASK_LSB  = 8;    // lowest bit of the priority mask
    localparam int SR_USER_BITS = 8;    // bits writable from user mode

endpackage

// File: rtl/irq_accept.sv
`timescale 1ns/1ps
// Acceptance decision. Compares the offered level with the mask at an
// instruction boundary and treats the top level as non-maskable.
// Assumes the sequencer is idle when idle=1 and that a return start
// has priority over entry. NMI_EDGE=1 makes the top level
// edge-triggered with a pending flag; NMI_EDGE=0 makes it level-taken.
module irq_accept #(
    parameter int LVL_W    = 3,
    parameter bit NMI_EDGE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic             idle,
    input  logic             rte_start,
    input  logic [LVL_W-1:0] req_level,
    input  logic [LVL_W-1:0] mask,
    output logic             take,
    output logic [LVL_W-1:0] take_level
);

    localparam logic [LVL_W-1:0] TOP_LEVEL = {LVL_W{1'b1}};

    logic top_now;
    logic nmi_eff;
    logic start_ok;
    logic maskable_hit;

    assign top_now = (req_level == TOP_LEVEL);

    generate
        if (NMI_EDGE) begin : g_edge
            logic top_prev;
            logic nmi_pend;
            logic top_rise;

            assign top_rise = top_now & ~top_prev;
            assign nmi_eff  = nmi_pend | top_rise;

            // Remember whether the top level was offered last cycle
            always_ff @(posedge clk) begin
                if (!rst_n) top_prev <= 1'b0;
                else        top_prev <= top_now;
            end

            // Hold a top-level transition until it has been taken
            always_ff @(posedge clk) begin
                if (!rst_n) nmi_pend <= 1'b0;
                else        nmi_pend <= nmi_eff & ~take;
            end
        end else begin : g_level
            assign nmi_eff = top_now;
        end
    endgenerate

    // Entry may start only at a boundary, when idle, with no return pending
    assign start_ok     = boundary & idle & ~rte_start;
    // Lower levels must beat the mask strictly
    assign maskable_hit = ~top_now & (req_level > mask);

    assign take       = start_ok & (nmi_eff | maskable_hit);
    assign take_level = nmi_eff ? TOP_LEVEL : req_level;

endmodule

// File: rtl/irq_mem_mux.sv
`timescale 1ns/1ps
// Memory port steering. Turns the sequencer state into request,
// direction, size, address and write data. Purely combinational;
// assumes the sequencer holds its state until the access is acknowledged.
module irq_mem_mux
    import irq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int SR_W = 16
) (
    input  seq_state_t       state,
    input  logic [AW-1:0]    sp,
    input  logic [AW-1:0]    vaddr,
    input  logic [AW-1:0]    saved_pc,
    input  logic [SR_W-1:0]  sr,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_long,
    output logic [AW-1:0]    mem_addr,
    output logic [AW-1:0]    mem_wdata
);

    localparam logic [AW-1:0] PC_BYTES = AW'(AW / 8);
    localparam logic [AW-1:0] SR_BYTES = AW'(SR_W / 8);

    // Decode access kind and address from the current state
    always_comb begin
        mem_req   = 1'b1;
        mem_we    = 1'b0;
        mem_long  = 1'b0;
        mem_addr  = sp;
        mem_wdata = '0;
        unique case (state)
            ST_PUSH_PC: begin
                mem_we    = 1'b1;
                mem_long  = 1'b1;
                mem_addr  = sp - PC_BYTES;
                mem_wdata = saved_pc;
            end
            ST_PUSH_SR: begin
                mem_we    = 1'b1;
                mem_addr  = sp - SR_BYTES;
                mem_wdata = {{(AW-SR_W){1'b0}}, sr};
            end
            ST_VEC_RD: begin
                mem_long  = 1'b1;
                mem_addr  = vaddr;
            end
            ST_POP_SR: begin
                mem_addr  = sp;
            end
            ST_POP_PC: begin
                mem_long  = 1'b1;
                mem_addr  = sp;
            end
            default: begin
                mem_req   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/irq_stacker.sv
`timescale 1ns/1ps
// Entry/return sequencer. Owns the status register and the supervisor
// stack pointer and walks the stacking, vector-read and restore steps,
// one memory access per state. Assumes mem_ack is a single-cycle
// completion for the access currently requested.
module irq_stacker
    import irq_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            LVL_W     = 3,
    parameter int            VEC_W     = 8,
    parameter int            SR_W      = 16,
    parameter logic [AW-1:0] STACK_TOP = 32'h0000_2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [LVL_W-1:0] take_level,
    input  logic [VEC_W-1:0] take_vector,
    input  logic [AW-1:0]    take_pc,
    input  logic             rte_start,
    input  logic             sr_wr_en,
    input  logic [SR_W-1:0]  sr_wr_data,
    input  logic             mem_ack,
    input  logic [AW-1:0]    mem_rdata,
    output seq_state_t       state,
    output logic             idle,
    output logic [AW-1:0]    sp,
    output logic [SR_W-1:0]  sr,
    output logic [AW-1:0]    vaddr,
    output logic [AW-1:0]    saved_pc,
    output logic             accept,
    output logic [LVL_W-1:0] accept_level,
    output logic             jump,
    output logic [AW-1:0]    jump_pc
);

    localparam logic [AW-1:0]   PC_BYTES = AW'(AW / 8);
    localparam logic [AW-1:0]   SR_BYTES = AW'(SR_W / 8);
    localparam logic [SR_W-1:0] SR_INIT  =
        SR_W'((1 << SR_SUPER_BIT) | (((1 << LVL_W) - 1) << SR_MASK_LSB));

    seq_state_t      state_q;
    logic [SR_W-1:0] sr_q;
    logic [AW-1:0]   sp_q;
    logic [LVL_W-1:0] lvl_q;
    logic [AW-1:0]   vaddr_q;
    logic [AW-1:0]   pc_q;
    logic            accept_q;
    logic            jump_q;
    logic [AW-1:0]   jump_pc_q;
    logic            in_super;

    assign in_super = sr_q[SR_SUPER_BIT];

    // Step through entry and return sequences, one access per state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rte_start)  state_q <= ST_POP_SR;
                    else if (take)  state_q <= ST_PUSH_PC;
                end
                ST_PUSH_PC: if (mem_ack) state_q <= ST_PUSH_SR;
                ST_PUSH_SR: if (mem_ack) state_q <= ST_VEC_RD;
                ST_VEC_RD:  if (mem_ack) state_q <= ST_IDLE;
                ST_POP_SR:  if (mem_ack) state_q <= ST_POP_PC;
                ST_POP_PC:  if (mem_ack) state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture level, vector address and return PC when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q   <= '0;
            vaddr_q <= '0;
            pc_q    <= '0;
        end else if (state_q == ST_IDLE && !rte_start && take) begin
            lvl_q   <= take_level;
            vaddr_q <= {{(AW-VEC_W-2){1'b0}}, take_vector, 2'b00};
            pc_q    <= take_pc;
        end
    end

    // Status register: software writes, entry update, return restore
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= SR_INIT;
        end else if (state_q == ST_IDLE) begin
            if (sr_wr_en) begin
                if (in_super)
                    sr_q <= sr_wr_data;
                else
                    sr_q[SR_USER_BITS-1:0] <= sr_wr_data[SR_USER_BITS-1:0];
            end
        end else if (state_q == ST_PUSH_SR && mem_ack) begin
            sr_q[SR_SUPER_BIT]             <= 1'b1;
            sr_q[SR_MASK_LSB +: LVL_W]     <= lvl_q;
        end else if (state_q == ST_POP_SR && mem_ack) begin
            sr_q <= mem_rdata[SR_W-1:0];
        end
    end

    // Stack pointer: lowered on each push, raised on each pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= STACK_TOP;
        end else if (mem_ack) begin
            unique case (state_q)
                ST_PUSH_PC: sp_q <= sp_q - PC_BYTES;
                ST_PUSH_SR: sp_q <= sp_q - SR_BYTES;
                ST_POP_SR:  sp_q <= sp_q + SR_BYTES;
                ST_POP_PC:  sp_q <= sp_q + PC_BYTES;
                default:    sp_q <= sp_q;
            endcase
        end
    end

    // One-cycle accept pulse in the first stacking cycle
    always_ff @(posedge clk) begin
        if (!rst_n) accept_q <= 1'b0;
        else        accept_q <= (state_q == ST_IDLE) && !rte_start && take;
    end

    // Jump pulse and target when the vector or return PC arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jump_q    <= 1'b0;
            jump_pc_q <= '0;
        end else begin
            jump_q <= 1'b0;
            if (mem_ack && (state_q == ST_VEC_RD || state_q == ST_POP_PC)) begin
                jump_q    <= 1'b1;
                jump_pc_q <= mem_rdata;
            end
        end
    end

    assign state        = state_q;
    assign idle         = (state_q == ST_IDLE);
    assign sp           = sp_q;
    assign sr           = sr_q;
    assign vaddr        = vaddr_q;
    assign saved_pc     = pc_q;
    assign accept       = accept_q;
    assign accept_level = lvl_q;
    assign jump         = jump_q;
    assign jump_pc      = jump_pc_q;

endmodule

// File: rtl/prio_irq_unit.sv
`timescale 1ns/1ps
// Top of the priority interrupt acceptance unit. Joins the acceptance
// decision, the entry/return sequencer and the memory port steering.
// Assumes a single stack (supervisor) and a memory port that answers
// each request with a one-cycle acknowledge.
module prio_irq_unit
    import irq_pkg::*;
#(
    parameter int            AW        = 32,
    parameter int            LVL_W     = 3,
    parameter int            VEC_W     = 8,
    parameter int            SR_W      = 16,
    parameter bit            NMI_EDGE  = 1'b1,
    parameter logic [AW-1:0] STACK_TOP = 32'h0000_2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             boundary,
    input  logic [LVL_W-1:0] req_level,
    input  logic [VEC_W-1:0] req_vector,
    input  logic [AW-1:0]    cur_pc,
    input  logic             rte_start,
    input  logic             sr_wr_en,
    input  logic [SR_W-1:0]  sr_wr_data,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_long,
    output logic [AW-1:0]    mem_addr,
    output logic [AW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [AW-1:0]    mem_rdata,
    output logic             busy,
    output logic             accept,
    output logic [LVL_W-1:0] accept_level,
    output logic [AW-1:0]    vec_addr,
    output logic             jump,
    output logic [AW-1:0]    jump_pc,
    output logic [SR_W-1:0]  sr,
    output logic [AW-1:0]    sp
);

    seq_state_t       state_w;
    logic             idle_w;
    logic             take_w;
    logic [LVL_W-1:0] take_lvl_w;
    logic [AW-1:0]    sp_w;
    logic [SR_W-1:0]  sr_w;
    logic [AW-1:0]    vaddr_w;
    logic [AW-1:0]    pc_w;

    irq_accept #(
        .LVL_W    (LVL_W),
        .NMI_EDGE (NMI_EDGE)
    ) u_accept (
        .clk        (clk),
        .rst_n      (rst_n),
        .boundary   (boundary),
        .idle       (idle_w),
        .rte_start  (rte_start),
        .req_level  (req_level),
        .mask       (sr_w[SR_MASK_LSB +: LVL_W]),
        .take       (take_w),
        .take_level (take_lvl_w)
    );

    irq_stacker #(
        .AW        (AW),
        .LVL_W     (LVL_W),
        .VEC_W     (VEC_W),
        .SR_W      (SR_W),
        .STACK_TOP (STACK_TOP)
    ) u_stacker (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take_w),
        .take_level   (take_lvl_w),
        .take_vector  (req_vector),
        .take_pc      (cur_pc),
        .rte_start    (rte_start),
        .sr_wr_en     (sr_wr_en),
        .sr_wr_data   (sr_wr_data),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .state        (state_w),
        .idle         (idle_w),
        .sp           (sp_w),
        .sr           (sr_w),
        .vaddr        (vaddr_w),
        .saved_pc     (pc_w),
        .accept       (accept),
        .accept_level (accept_level),
        .jump         (jump),
        .jump_pc      (jump_pc)
    );

    irq_mem_mux #(
        .AW   (AW),
        .SR_W (SR_W)
    ) u_mux (
        .state     (state_w),
        .sp        (sp_w),
        .vaddr     (vaddr_w),
        .saved_pc  (pc_w),
        .sr        (sr_w),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_long  (mem_long),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign busy     = ~idle_w;
    assign vec_addr = vaddr_w;
    assign sr       = sr_w;
    assign sp       = sp_w;

endmodule

// File: rtl/irq_unit_chk.sv
`timescale 1ns/1ps
// Checker for the priority interrupt acceptance unit, bound to the top.
// Observes ports only.
module irq_unit_chk
    import irq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LVL_W = 3,
    parameter int VEC_W = 8,
    parameter int SR_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sr_wr_en,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_long,
    input logic [AW-1:0]    mem_addr,
    input logic             mem_ack,
    input logic             busy,
    input logic             accept,
    input logic [LVL_W-1:0] accept_level,
    input logic [AW-1:0]    vec_addr,
    input logic [SR_W-1:0]  sr,
    input logic [AW-1:0]    sp
);

    localparam logic [LVL_W-1:0] TOP_LEVEL = {LVL_W{1'b1}};
    localparam logic [AW-1:0]    VEC_END   = AW'(1 << (VEC_W + 2));

    AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (accept_level == TOP_LEVEL) ||
                   (accept_level > $past(sr[SR_MASK_LSB +: LVL_W]))); // R2

    AST_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (accept_level != '0)); // R2

    AST_PC_PUSH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> mem_req && mem_we && mem_long && (mem_addr == sp - AW'(4))); // R4

    AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (vec_addr[1:0] == 2'b00) && (vec_addr < VEC_END)); // R5

    AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept); // R5

    AST_USER_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr[SR_SUPER_BIT] && sr_wr_en && !busy) |=> $stable(sr[SR_W-1:SR_USER_BITS])); // R7

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R8

endmodule

bind prio_irq_unit irq_unit_chk #(
    .AW    (AW),
    .LVL_W (LVL_W),
    .VEC_W (VEC_W),
    .SR_W  (SR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sr_wr_en     (sr_wr_en),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_long     (mem_long),
    .mem_addr     (mem_addr),
    .mem_ack      (mem_ack),
    .busy         (busy),
    .accept       (accept),
    .accept_level (accept_level),
    .vec_addr     (vec_addr),
    .sr           (sr),
    .sp           (sp)
);

// File: tb/prio_irq_unit_test.sv
`timescale 1ns/1ps
module prio_irq_unit_test;

    localparam logic [31:0] TOP_SP = 32'h0000_2000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        boundary;
    logic [2:0]  req_level;
    logic [7:0]  req_vector;
    logic [31:0] cur_pc;
    logic        rte_start;
    logic        sr_wr_en;
    logic [15:0] sr_wr_data;
    logic        mem_req, mem_we, mem_long;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        busy, accept, jump;
    logic [2:0]  accept_level;
    logic [31:0] vec_addr, jump_pc, sp;
    logic [15:0] sr;

    prio_irq_unit #(.STACK_TOP(TOP_SP)) uut (
        .clk(clk), .rst_n(rst_n), .boundary(boundary), .req_level(req_level),
        .req_vector(req_vector), .cur_pc(cur_pc), .rte_start(rte_start),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .mem_req(mem_req),
        .mem_we(mem_we), .mem_long(mem_long), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .accept(accept), .accept_level(accept_level),
        .vec_addr(vec_addr), .jump(jump), .jump_pc(jump_pc), .sr(sr), .sp(sp)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int acc_cnt = 0;
    int jmp_cnt = 0;
    logic [2:0]  last_lvl;
    logic [31:0] last_vaddr, last_jpc;

    logic [7:0] mem [int];

    // bench model
    logic [15:0] e_sr;
    logic [31:0] e_sp;
    logic [2:0]  prev_lvl;
    bit          pend;
    logic [31:0] fr_pc [$];
    logic [15:0] fr_sr [$];

    function automatic logic [31:0] vec_target(input int v);
        return 32'h0004_0000 + 32'(v) * 32'd8;
    endfunction

    function automatic logic [31:0] rd32(input int a);
        return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
    endfunction

    function automatic logic [15:0] rd16(input int a);
        return {mem[a], mem[a+1]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder with random acknowledge delay (R8 stimulus)
    initial begin
        int dly;
        int a;
        dly = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                dly = $urandom_range(0, 2);
            end else if (mem_req) begin
                if (dly > 0) dly--;
                else begin
                    a = int'(mem_addr);
                    if (mem_we) begin
                        if (mem_long) begin
                            mem[a] = mem_wdata[31:24]; mem[a+1] = mem_wdata[23:16];
                            mem[a+2] = mem_wdata[15:8]; mem[a+3] = mem_wdata[7:0];
                        end else begin
                            mem[a] = mem_wdata[15:8]; mem[a+1] = mem_wdata[7:0];
                        end
                    end else begin
                        mem_rdata = mem_long ? rd32(a) : {16'h0, rd16(a)};
                    end
                    mem_ack = 1'b1;
                end
            end
        end
    end

    // pulse monitor
    initial begin
        forever begin
            @(negedge clk);
            if (accept) begin acc_cnt++; last_lvl = accept_level; last_vaddr = vec_addr; end
            if (jump) begin jmp_cnt++; last_jpc = jump_pc; end
        end
    end

    task automatic wait_idle();
        int g;
        g = 0;
        @(negedge clk);
        while (busy && g < 200) begin @(negedge clk); g++; end
        @(negedge clk);
    endtask

    task automatic drive_irq(input logic [2:0] lvl, input logic [7:0] vec,
                             input logic [31:0] pc, input bit strobe);
        bit rise, peff, take;
        logic [2:0] tl;
        int a0, j0;
        logic [15:0] old_sr;
        rise = (lvl == 3'd7) && (prev_lvl != 3'd7);
        peff = pend || rise;
        take = strobe && (peff || (lvl != 3'd7 && lvl > e_sr[10:8]));
        tl = peff ? 3'd7 : lvl;
        pend = peff && !take;
        prev_lvl = lvl;
        a0 = acc_cnt; j0 = jmp_cnt; old_sr = e_sr;
        @(negedge clk);
        req_level = lvl; req_vector = vec; cur_pc = pc; boundary = strobe;
        @(negedge clk);
        boundary = 1'b0;
        wait_idle();
        if (take) begin
            chk("R2/R3 accept count", 32'(acc_cnt), 32'(a0 + 1));
            chk("R5 accept level", 32'(last_lvl), 32'(tl));
            chk("R5 vector address", last_vaddr, {22'h0, vec, 2'b00});
            chk("R5 jump target", last_jpc, vec_target(int'(vec)));
            chk("R4 stacked pc", rd32(int'(e_sp) - 4), pc);
            chk("R4 stacked sr", 32'(rd16(int'(e_sp) - 6)), 32'(old_sr));
            e_sp = e_sp - 6;
            e_sr = old_sr;
            e_sr[13] = 1'b1;
            e_sr[10:8] = tl;
            chk("R4 sp after entry", sp, e_sp);
            chk("R5 sr after entry", 32'(sr), 32'(e_sr));
            fr_pc.push_back(pc);
            fr_sr.push_back(old_sr);
        end else begin
            chk("R2/R3 no accept", 32'(acc_cnt), 32'(a0));
            chk("R2/R3 no jump", 32'(jmp_cnt), 32'(j0));
            chk("R2/R3 sp kept", sp, e_sp);
            chk("R2/R3 sr kept", 32'(sr), 32'(e_sr));
        end
    endtask

    task automatic do_rte(input bit with_edge7);
        int j0, a0;
        logic [31:0] pc;
        logic [15:0] s;
        j0 = jmp_cnt; a0 = acc_cnt;
        pc = fr_pc.pop_back();
        s = fr_sr.pop_back();
        @(negedge clk);
        rte_start = 1'b1;
        if (with_edge7) begin
            req_level = 3'd7; boundary = 1'b1;
            pend = pend || (prev_lvl != 3'd7);
            prev_lvl = 3'd7;
        end
        @(negedge clk);
        rte_start = 1'b0; boundary = 1'b0;
        wait_idle();
        e_sr = s;
        e_sp = e_sp + 6;
        chk("R6 sr restored", 32'(sr), 32'(e_sr));
        chk("R6 sp after return", sp, e_sp);
        chk("R6 jump count", 32'(jmp_cnt), 32'(j0 + 1));
        chk("R6 return address", last_jpc, pc);
        if (with_edge7) chk("R9 return wins over request", 32'(acc_cnt), 32'(a0));
    endtask

    task automatic write_sr(input logic [15:0] d);
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_data = d;
        @(negedge clk);
        sr_wr_en = 1'b0;
        if (e_sr[13]) e_sr = d;
        else e_sr[7:0] = d[7:0];
        chk("R7 sr after write", 32'(sr), 32'(e_sr));
    endtask

    // watchdog
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; boundary = 1'b0; req_level = 3'd0; req_vector = 8'd0;
        cur_pc = '0; rte_start = 1'b0; sr_wr_en = 1'b0; sr_wr_data = '0;
        for (int v = 0; v < 256; v++) begin
            logic [31:0] t;
            t = vec_target(v);
            mem[v*4] = t[31:24]; mem[v*4+1] = t[23:16];
            mem[v*4+2] = t[15:8]; mem[v*4+3] = t[7:0];
        end
        e_sr = 16'h2700; e_sp = TOP_SP; prev_lvl = 3'd0; pend = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset sr", 32'(sr), 32'h2700);
        chk("R1 reset sp", sp, TOP_SP);
        chk("R1 reset idle", {28'h0, busy, accept, jump, mem_req}, 32'h0);

        // R7 supervisor write, mask becomes 3
        write_sr(16'h2300);
        // R2 equal level ignored, higher level without strobe ignored
        drive_irq(3'd3, 8'd70, 32'h0000_1230, 1'b1);
        drive_irq(3'd4, 8'd71, 32'h0000_1240, 1'b0);
        // R2 higher level at strobe taken; R4/R5 stacking
        drive_irq(3'd4, 8'd64, 32'h0000_1250, 1'b1);
        drive_irq(3'd4, 8'd65, 32'h0000_1260, 1'b1);
        // R3 top level taken over mask 4, then held (no retake)
        drive_irq(3'd7, 8'd66, 32'h0000_1270, 1'b1);
        drive_irq(3'd7, 8'd67, 32'h0000_1280, 1'b1);
        // R3 drop and raise again: taken under mask 7
        drive_irq(3'd0, 8'd0, 32'h0000_1290, 1'b1);
        drive_irq(3'd7, 8'd68, 32'h0000_12a0, 1'b1);
        // R6 returns
        do_rte(1'b0);
        do_rte(1'b0);
        // R7 enter user mode, then try to raise mask from user mode
        write_sr(16'h0005);
        write_sr(16'h2733);
        // R2 level 0 never taken, level 1 taken from mask 0
        drive_irq(3'd0, 8'd90, 32'h0000_4000, 1'b1);
        drive_irq(3'd1, 8'd91, 32'h0000_4010, 1'b1);
        // R9 return collides with a fresh top-level edge; edge stays pending
        do_rte(1'b0);
        drive_irq(3'd2, 8'd92, 32'h0000_4020, 1'b1);
        drive_irq(3'd1, 8'd93, 32'h0000_4030, 1'b0);
        do_rte(1'b1);
        drive_irq(3'd7, 8'd94, 32'h0000_4040, 1'b1);

        // constrained random phase
        for (int i = 0; i < 120; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op <= 5 || (op <= 7 && fr_pc.size() == 0)) begin
                drive_irq(3'($urandom_range(0, 7)), 8'($urandom_range(0, 255)),
                          {$urandom_range(0, 32'h7fff_ffff), 1'b0} & 32'hffff_fffe,
                          $urandom_range(0, 4) != 0);
            end else if (op <= 7) begin
                do_rte(1'b0);
            end else begin
                write_sr(16'($urandom_range(0, 16'hffff)));
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule